// File: doc/BRIEF.md
# Shift-Subtract Folding Modular Multiplier

This block multiplies two residues modulo a prime of the form p = k·2^m + 1, where k = 2^t − 1, and returns a fully reduced residue. The raw product is folded twice. Each fold splits its operand at bit m into a low part and a high part, then forms k·low − high. Because k·2^m ≡ −1 (mod p), every fold multiplies the value's residue by k. After two folds the result is congruent to k²·a·b. Multiplying by k is done as (x << t) − x, so the folding stages contain only adders, shifters and subtractors. The only true multiplier in the block is the a·b product.

The folded value is signed and lies within a small window around [0, p). A final stage brings it into [0, p) by adding p, subtracting p, or passing it through. The choice is made from two sign tests: the sign of the folded value, and the sign of the folded value minus p. Callers that want a·b mod p fold the constant k⁻² into one operand beforehand; that precomputation sits outside this block. The block is a three-stage pipeline that accepts one operation per cycle and is configured at elaboration for one of three prime sets.

Top module: `kred_modmul`

## Requirements
- R1: When valid_o is 1, result_o equals (k²·a·b) mod p and lies in [0, p), where a and b are the operands presented with the matching valid_i. Both operands must be below p.
- R2: An operation presented on a clock edge with valid_i = 1 appears on result_o after exactly three rising edges. A new operation may be presented on every cycle.
- R3: valid_o equals valid_i delayed by three rising edges. valid_o is 0 whenever no operation is completing.
- R4: While valid_o is 0, result_o holds the last completed result. Operands presented with valid_i = 0 have no effect on result_o.
- R5: While rst_ni is 0, valid_o and result_o are 0. This holds asynchronously and also when reset is applied in the middle of a stream.
- R6: MOD_SEL selects the prime set (m, t, width): 0 gives (9, 4, 13) with p = 7681 and k = 15; 1 gives (13, 10, 23) with p = 8380417 and k = 1023; 2 gives (12, 2, 14) with p = 12289 and k = 3.
- R7: A zero operand gives 0. The operands (p−1, p−1) give k² mod p, which is 225, 1046529 and 9 for the three sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands on a_i and b_i are valid |
| a_i | input | N | First operand, below p |
| b_i | input | N | Second operand, below p |
| valid_o | output | 1 | result_o holds a new result |
| result_o | output | N | (k²·a·b) mod p |

## Verification
The hardest cases to reach from the ports are the ones where the final stage must add p or subtract p. These happen only when the second fold lands just below zero or at or above p. That in turn needs the first fold's high part to nearly cancel k times its low part. The stimulus drives extreme operands (p−1, 1, 2) and several hundred random operand pairs on three instances with different prime sets, so that both correction paths are hit. The checker confirms that the folded value always stays inside the window that a single correction can handle.

// File: rtl/kred_pkg.sv
package kred_pkg;
  // prime sets: p = (2^t - 1) * 2^m + 1
  localparam int unsigned SET_M [3] = '{9, 13, 12};
  localparam int unsigned SET_T [3] = '{4, 10, 2};
  localparam int unsigned SET_N [3] = '{13, 23, 14};
endpackage

// File: rtl/kred_fold.sv
// One fold: y = k*x[M-1:0] - (x >>> M), with k = 2^T - 1
module kred_fold #(
  parameter int unsigned IN_W  = 27,
  parameter int unsigned OUT_W = 26,
  parameter int unsigned M     = 9,
  parameter int unsigned T     = 4
) (
  input  logic signed [IN_W-1:0]  x_i,
  output logic signed [OUT_W-1:0] y_o
);
  localparam int unsigned IW = IN_W + T + 2;

  logic signed [IW-1:0] lo_x, hi_x, k_lo;

  always_comb begin
    lo_x = $signed({{(IW-M){1'b0}}, x_i[M-1:0]});
    hi_x = IW'(x_i >>> M);
    k_lo = (lo_x <<< T) - lo_x;
    y_o  = OUT_W'(k_lo - hi_x);
  end
endmodule

// File: rtl/kred_fix.sv
// Bring a value in (-p, 2p) into [0, p) from two sign tests
module kred_fix #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 13,
  parameter int unsigned P = 7681
) (
  input  logic signed [W-1:0] z_i,
  output logic [N-1:0]        r_o
);
  localparam logic signed [W-1:0] P_S = W'(P);

  logic [1:0] code;

  always_comb begin
    code = {z_i < 0, z_i >= P_S};
    unique case (code)
      2'b10:   r_o = N'(z_i + P_S);
      2'b01:   r_o = N'(z_i - P_S);
      default: r_o = N'(z_i);
    endcase
  end
endmodule

// File: rtl/kred_modmul.sv
module kred_modmul #(
  parameter int unsigned MOD_SEL = 1,
  localparam int unsigned M  = kred_pkg::SET_M[MOD_SEL],
  localparam int unsigned T  = kred_pkg::SET_T[MOD_SEL],
  localparam int unsigned N  = kred_pkg::SET_N[MOD_SEL]
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic         valid_o,
  output logic [N-1:0] result_o
);
  localparam int unsigned K  = (1 << T) - 1;
  localparam int unsigned P  = K * (1 << M) + 1;
  localparam int unsigned ZW = 2 * N;
  localparam int unsigned W1 = 2 * N + 2;
  localparam int unsigned W2 = N + 3;

  logic [ZW-1:0]        prod;
  logic signed [W1-1:0] z1_d, z1_q;
  logic signed [W2-1:0] z2_d, z2_q;
  logic [N-1:0]         r_d, r_q;
  logic                 v1_q, v2_q, v3_q;

  // stage 1: product and first fold
  assign prod = ZW'(a_i) * ZW'(b_i);

  kred_fold #(.IN_W(ZW + 1), .OUT_W(W1), .M(M), .T(T)) u_fold1 (
    .x_i ($signed({1'b0, prod})),
    .y_o (z1_d)
  );

  // stage 2: second fold
  kred_fold #(.IN_W(W1), .OUT_W(W2), .M(M), .T(T)) u_fold2 (
    .x_i (z1_q),
    .y_o (z2_d)
  );

  // stage 3: correction
  kred_fix #(.W(W2), .N(N), .P(P)) u_fix (
    .z_i (z2_q),
    .r_o (r_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
      z1_q <= '0;
      z2_q <= '0;
      r_q  <= '0;
    end else begin
      v1_q <= valid_i;
      v2_q <= v1_q;
      v3_q <= v2_q;
      if (valid_i) z1_q <= z1_d;
      if (v1_q)    z2_q <= z2_d;
      if (v2_q)    r_q  <= r_d;
    end
  end

  assign valid_o  = v3_q;
  assign result_o = r_q;
endmodule

// File: rtl/kred_modmul_chk.sv
module kred_modmul_chk #(
  parameter int unsigned N  = 23,
  parameter int unsigned W2 = 26,
  parameter longint      P  = 8380417,
  parameter longint      K  = 1023
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic                 valid_o,
  input logic [N-1:0]         result_o,
  input logic                 v2_q,
  input logic signed [W2-1:0] z2_q
);
  logic [2:0] vsh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vsh <= '0;
    else         vsh <= {vsh[1:0], valid_i};
  end

  // R3
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == vsh[2]);

  // R1
  result_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> longint'(result_o) < P);

  // R1: second fold stays inside the single-correction window
  fold_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v2_q |-> (longint'(z2_q) > -K) && (longint'(z2_q) <= P + K * K));

  // R4
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o));

  // R5
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (!valid_o && result_o == '0);
    end
  end
endmodule

bind kred_modmul kred_modmul_chk #(
  .N(N), .W2(W2), .P(longint'(P)), .K(longint'(K))
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .valid_o  (valid_o),
  .result_o (result_o),
  .v2_q     (v2_q),
  .z2_q     (z2_q)
);

// File: tb/kred_modmul_tb_top.sv
module kred_modmul_tb_top;
  localparam longint PB [3] = '{7681, 8380417, 12289};
  localparam longint KB [3] = '{15, 1023, 3};
  // set 1 table: a, b, expected (k^2*a*b mod p)
  localparam int NV = 6;
  localparam longint TAB [NV][3] = '{
    '{0,       12345,   0},        // R7
    '{1,       1,       1046529},
    '{1,       2,       2093058},
    '{8380416, 8380416, 1046529},  // R7
    '{2,       8380416, 6287359},
    '{8380416, 1,       7333888}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [12:0] a0, b0;
  logic [22:0] a1, b1;
  logic [13:0] a2, b2;
  logic [12:0] r0;
  logic [22:0] r1;
  logic [13:0] r2;
  logic [2:0]  vo;

  always #4 clk = ~clk;

  kred_modmul #(.MOD_SEL(0)) dut_s0 (.clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .a_i(a0), .b_i(b0), .valid_o(vo[0]), .result_o(r0));
  kred_modmul #(.MOD_SEL(1)) dut_i (.clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .a_i(a1), .b_i(b1), .valid_o(vo[1]), .result_o(r1));
  kred_modmul #(.MOD_SEL(2)) dut_s2 (.clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .a_i(a2), .b_i(b2), .valid_o(vo[2]), .result_o(r2));

  int nchk = 0, nerr = 0;
  bit done = 0;
  bit hv [3][3];
  longint hx [3][3];
  longint last_r [3];

  function automatic longint model(int s, longint a, longint b);
    longint p = PB[s];
    return ((KB[s] * KB[s]) % p) * ((a * b) % p) % p;
  endfunction

  function automatic longint res_of(int s);
    return (s == 0) ? longint'(r0) : (s == 1) ? longint'(r1) : longint'(r2);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int s = 0; s < 3; s++) begin
      for (int d = 0; d < 3; d++) begin hv[s][d] = 0; hx[s][d] = 0; end
      last_r[s] = 0;
    end
  endtask

  // e1 >= 0 overrides the set-1 expectation (table walk)
  task automatic step(bit v, longint x0, longint y0, longint x1, longint y1,
                      longint x2, longint y2, longint e1);
    @(negedge clk);
    for (int s = 0; s < 3; s++) begin
      if (hv[s][2]) begin
        chk(vo[s] == 1'b1, s == 1 ? "R3 valid_o set" : "R6 R3 valid_o set", vo[s], 1);
        chk(res_of(s) == hx[s][2], s == 1 ? "R1 R2 result" : "R6 result",
            res_of(s), hx[s][2]);
        last_r[s] = hx[s][2];
      end else begin
        chk(vo[s] == 1'b0, "R3 valid_o clear", vo[s], 0);
        chk(res_of(s) == last_r[s], "R4 result held", res_of(s), last_r[s]);
      end
      hv[s][2] = hv[s][1]; hx[s][2] = hx[s][1];
      hv[s][1] = hv[s][0]; hx[s][1] = hx[s][0];
    end
    hv[0][0] = v; hx[0][0] = model(0, x0, y0);
    hv[1][0] = v; hx[1][0] = (e1 >= 0) ? e1 : model(1, x1, y1);
    hv[2][0] = v; hx[2][0] = model(2, x2, y2);
    valid_i = v;
    a0 = 13'(x0); b0 = 13'(y0);
    a1 = 23'(x1); b1 = 23'(y1);
    a2 = 14'(x2); b2 = 14'(y2);
  endtask

  task automatic rnd_step(bit v);
    step(v, $urandom % PB[0], $urandom % PB[0], $urandom % PB[1], $urandom % PB[1],
         $urandom % PB[2], $urandom % PB[2], -1);
  endtask

  task automatic check_reset_outputs(string tag);
    for (int s = 0; s < 3; s++) begin
      chk(vo[s] == 1'b0, tag, vo[s], 0);
      chk(res_of(s) == 0, tag, res_of(s), 0);
    end
  endtask

  initial begin
    a0 = '0; b0 = '0; a1 = '0; b1 = '0; a2 = '0; b2 = '0;
    clear_hist();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_outputs("R5 reset state");
    rst_ni = 1'b1;

    // table walk, back to back (R1 R2 R7)
    for (int i = 0; i < NV; i++)
      step(1, TAB[i][0] % PB[0], TAB[i][1] % PB[0], TAB[i][0], TAB[i][1],
           TAB[i][0] % PB[2], TAB[i][1] % PB[2], TAB[i][2]);
    // R7 extremes on the other sets
    step(1, PB[0] - 1, PB[0] - 1, 0, 5, PB[2] - 1, PB[2] - 1, 0);
    step(1, 0, 77, 3, 0, 0, 0, 0);
    // R4: idle operands must not disturb result
    for (int i = 0; i < 5; i++) rnd_step(0);
    // R7 explicit values at the ports
    chk(r0 == 13'd0 && r1 == 23'd0 && r2 == 14'd0, "R7 zero operand", r1, 0);

    step(1, PB[0] - 1, PB[0] - 1, PB[1] - 1, PB[1] - 1, PB[2] - 1, PB[2] - 1, -1);
    for (int i = 0; i < 3; i++) rnd_step(0);
    chk(r0 == 13'd225, "R7 set0 k^2", r0, 225);
    chk(r1 == 23'd1046529, "R7 set1 k^2", r1, 1046529);
    chk(r2 == 14'd9, "R7 set2 k^2", r2, 9);

    // random streams (R1 R2 R3 R6)
    for (int i = 0; i < 400; i++) rnd_step(1);
    for (int i = 0; i < 600; i++) rnd_step(($urandom % 3) != 0);
    for (int i = 0; i < 4; i++) rnd_step(0);

    // R5 mid-stream reset
    for (int i = 0; i < 2; i++) rnd_step(1);
    @(negedge clk);
    rst_ni = 1'b0;
    valid_i = 1'b0;
    #1;
    check_reset_outputs("R5 async reset");
    clear_hist();
    @(negedge clk);
    check_reset_outputs("R5 reset hold");
    rst_ni = 1'b1;
    for (int i = 0; i < 50; i++) rnd_step(1);
    for (int i = 0; i < 4; i++) rnd_step(0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule